// File: doc/BRIEF.md
# Cascadable Loadable Binary Counter Slice

A synchronous up counter built from identical 4-bit slices that are chained into one wide counter. Each slice changes state on the rising clock edge, except for an active-low master clear. The clear acts at once, with no clock needed. A slice can take a parallel load from its data inputs. Otherwise it counts when two enables are both high: a parallel enable shared by every slice, and a trickle enable that comes from the slice below.

Each slice makes a terminal-count signal from its trickle enable and its own bits. That signal feeds the trickle enable of the next more-significant slice. The signal is combinational, so the chain works as a look-ahead carry: in the same cycle, a slice knows whether every slice below it is at all ones. The top level builds a chain of `NUM_SLICES` slices. To the outside it looks like one counter of `SLICE_W*NUM_SLICES` bits, with one shared clear, load and parallel enable, a trickle enable into the lowest slice, and the terminal count of the highest slice.

Top module: `casc_counter`

## Requirements
- R1: While clr_n is 0, q and tc are 0 at once, without a clock edge and whatever the other inputs are.
- R2: With clr_n at 1 and load_n at 0 at a rising edge, q takes the value of din, whatever en_par and en_trk are.
- R3: With clr_n, load_n, en_par and en_trk all at 1 at a rising edge, q becomes q+1 as one wide binary number.
- R4: With clr_n and load_n at 1 and either en_par or en_trk at 0 at a rising edge, q keeps its value.
- R5: tc is 1 exactly when en_trk is 1 and every bit of q is 1. tc follows a change on en_trk in the same cycle, with no clock edge.
- R6: When q is all ones and the count condition of R3 holds, the next rising edge takes q to 0.
- R7: The trickle enable of each slice above the lowest is the terminal count of the slice below. A slice advances only when every lower slice is all ones.
- R8: Clear overrides load, and load overrides count. After clr_n returns to 1, the first rising edge acts normally.
- R9: Changes on load_n, en_par, en_trk and din between rising edges have no effect on q, provided they are back before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Parallel count enable shared by all slices |
| en_trk | input | 1 | Trickle count enable of the lowest slice |
| din | input | SLICE_W*NUM_SLICES | Parallel load data |
| q | output | SLICE_W*NUM_SLICES | Counter value |
| tc | output | 1 | Terminal count of the highest slice |

## Verification
The assertions check these on every cycle:
- the clear value;
- load, increment and hold as one wide counter;
- the terminal count against the full width;
- that no upper slice steps unless all lower bits are ones.

Only the bench's scenarios show the following:
- clear taking hold between edges, before any clock;
- tc following en_trk within the same cycle;
- the first edge after clear release;
- input glitches between edges being ignored.

A full 4096-step sweep covers every carry across the slice boundaries and the wrap to zero.

// File: rtl/cnt_chain_pkg.sv
package cnt_chain_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_LOAD = 2'd1,
    MODE_STEP = 2'd2
  } slice_mode_e;

  // Load beats counting; counting needs both enables.
  function automatic slice_mode_e pick_mode(input logic load_n,
                                            input logic en_par,
                                            input logic en_trk);
    if (!load_n)
      return MODE_LOAD;
    else if (en_par && en_trk)
      return MODE_STEP;
    else
      return MODE_HOLD;
  endfunction

endpackage

// File: rtl/slice_state_reg.sv
module slice_state_reg
  import cnt_chain_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic               clk,
  input  logic               clr_n,
  input  slice_mode_e        mode,
  input  logic [SLICE_W-1:0] din,
  output logic [SLICE_W-1:0] q
);

  localparam logic [SLICE_W-1:0] ONE = SLICE_W'(1);

  function automatic logic [SLICE_W-1:0] next_val(input slice_mode_e m,
                                                  input logic [SLICE_W-1:0] cur,
                                                  input logic [SLICE_W-1:0] d);
    case (m)
      MODE_LOAD: return d;
      MODE_STEP: return cur + ONE;
      default:   return cur;
    endcase
  endfunction

  logic [SLICE_W-1:0] q_r;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)
      q_r <= '0;
    else
      q_r <= next_val(mode, q_r, din);
  end

  assign q = q_r;

endmodule

// File: rtl/slice_tc_gen.sv
module slice_tc_gen #(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] q,
  input  logic               en_trk,
  output logic               tc
);

  function automatic logic at_top(input logic [SLICE_W-1:0] v);
    return &v;
  endfunction

  assign tc = en_trk & at_top(q);

endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import cnt_chain_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               load_n,
  input  logic               en_par,
  input  logic               en_trk,
  input  logic [SLICE_W-1:0] din,
  output logic [SLICE_W-1:0] q,
  output logic               tc,
  output logic               step_evt
);

  slice_mode_e mode;

  assign mode     = pick_mode(load_n, en_par, en_trk);
  assign step_evt = (mode == MODE_STEP);

  slice_state_reg #(.SLICE_W(SLICE_W)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .mode  (mode),
    .din   (din),
    .q     (q)
  );

  slice_tc_gen #(.SLICE_W(SLICE_W)) u_tc (
    .q      (q),
    .en_trk (en_trk),
    .tc     (tc)
  );

endmodule

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter  int SLICE_W    = 4,
  parameter  int NUM_SLICES = 3,
  localparam int TOTAL_W    = SLICE_W * NUM_SLICES
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               load_n,
  input  logic               en_par,
  input  logic               en_trk,
  input  logic [TOTAL_W-1:0] din,
  output logic [TOTAL_W-1:0] q,
  output logic               tc
);

  // trk_chain[k] is the trickle enable of slice k; trk_chain[k+1] is its tc (R7)
  logic [NUM_SLICES:0]   trk_chain;
  logic [NUM_SLICES-1:0] slice_step;

  assign trk_chain[0] = en_trk;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    cnt_slice #(.SLICE_W(SLICE_W)) u_slice (
      .clk      (clk),
      .clr_n    (clr_n),
      .load_n   (load_n),
      .en_par   (en_par),
      .en_trk   (trk_chain[k]),
      .din      (din[k*SLICE_W +: SLICE_W]),
      .q        (q[k*SLICE_W +: SLICE_W]),
      .tc       (trk_chain[k+1]),
      .step_evt (slice_step[k])
    );
  end

  assign tc = trk_chain[NUM_SLICES];

endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter  int SLICE_W    = 4,
  parameter  int NUM_SLICES = 3,
  localparam int TOTAL_W    = SLICE_W * NUM_SLICES
) (
  input logic                  clk,
  input logic                  clr_n,
  input logic                  load_n,
  input logic                  en_par,
  input logic                  en_trk,
  input logic [TOTAL_W-1:0]    din,
  input logic [TOTAL_W-1:0]    q,
  input logic                  tc,
  input logic [NUM_SLICES-1:0] slice_step
);

  localparam logic [TOTAL_W-1:0] ONE_W = TOTAL_W'(1);

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    !clr_n |-> (q == '0) && !tc);  // R1

  AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));  // R2

  AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk) |=> q == ($past(q) + ONE_W));  // R3

  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_par && en_trk)) |=> $stable(q));  // R4

  AST_WIDE_TC: assert property (@(posedge clk) disable iff (!clr_n)
    tc == (en_trk && (&q)));  // R5

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk && (&q)) |=> q == '0);  // R6

  for (genvar k = 1; k < NUM_SLICES; k++) begin : g_casc
    AST_UPPER_NEEDS_LOWER: assert property (@(posedge clk) disable iff (!clr_n)
      slice_step[k] |-> (&q[k*SLICE_W-1:0]));  // R7
  end

endmodule

bind casc_counter casc_counter_chk #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_chk (
  .clk        (clk),
  .clr_n      (clr_n),
  .load_n     (load_n),
  .en_par     (en_par),
  .en_trk     (en_trk),
  .din        (din),
  .q          (q),
  .tc         (tc),
  .slice_step (slice_step)
);

// File: tb/casc_counter_test.sv
module casc_counter_test;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 4;
  localparam int NS = 3;
  localparam int TW = SW * NS;
  localparam logic [TW-1:0] ALL_ONES = {TW{1'b1}};

  logic          clk = 1'b0;
  logic          clr_n, load_n, en_par, en_trk;
  logic [TW-1:0] din, q;
  logic          tc;

  int n_tests = 0;
  int n_fail  = 0;
  logic [TW-1:0] model;

  casc_counter #(.SLICE_W(SW), .NUM_SLICES(NS)) uut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .din(din), .q(q), .tc(tc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [TW-1:0] act, input logic [TW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle: inputs set at negedge, tc checked before the edge, q after it.
  task automatic cycle(input logic ln, input logic ep, input logic et,
                       input logic [TW-1:0] d);
    string tag;
    @(negedge clk);
    load_n = ln; en_par = ep; en_trk = et; din = d;
    #1;
    check("R5", "tc", TW'(tc), TW'(et && (model == ALL_ONES)));
    if (!ln) begin
      tag = "R2"; model = d;
    end else if (ep && et) begin
      if (model == ALL_ONES)             tag = "R6";
      else if (&model[SW-1:0])           tag = "R7";
      else                               tag = "R3";
      model = model + 1'b1;
    end else begin
      tag = "R4";
    end
    @(posedge clk);
    #2;
    check(tag, "q", q, model);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clr_n = 1'b0; load_n = 1'b0; en_par = 1'b1; en_trk = 1'b1; din = 12'hABC;
    model = '0;
    #2;
    check("R1", "q under clear", q, '0);
    check("R1", "tc under clear", TW'(tc), '0);
    @(posedge clk); #2;
    check("R8", "clear beats load", q, '0);

    // Release clear mid-cycle; the first edge counts.
    @(negedge clk);
    clr_n = 1'b1; load_n = 1'b1;
    @(posedge clk); #2;
    model = 12'd1;
    check("R8", "first edge after release", q, model);

    // Full sweep: every carry and the wrap.
    cycle(1'b0, 1'b0, 1'b0, '0);
    for (int i = 0; i < 4096; i++) cycle(1'b1, 1'b1, 1'b1, '0);
    check("R6", "sweep returns to zero", q, '0);

    // Load overrides every enable combination; hold for each non-count pair.
    for (int c = 0; c < 4; c++) begin
      cycle(1'b0, c[0], c[1], 12'h0F0 + TW'(c));
      if (c != 3) begin
        cycle(1'b1, c[0], c[1], '0);
        cycle(1'b1, c[0], c[1], '0);
      end
    end

    // tc follows en_trk in the same cycle (R5).
    cycle(1'b0, 1'b0, 1'b0, ALL_ONES);
    @(negedge clk);
    load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0; #1;
    check("R5", "tc with trickle low", TW'(tc), '0);
    en_trk = 1'b1; #1;
    check("R5", "tc follows trickle", TW'(tc), 12'd1);
    en_trk = 1'b0; #1;
    check("R5", "tc drops with trickle", TW'(tc), '0);
    cycle(1'b1, 1'b1, 1'b1, '0);

    // Glitches between edges have no effect (R9).
    cycle(1'b0, 1'b0, 1'b0, 12'h3A7);
    for (int g = 0; g < 4; g++) begin
      @(negedge clk);
      load_n = 1'b0; en_par = 1'b1; en_trk = 1'b1; din = 12'h111 * TW'(g + 1);
      #1; load_n = 1'b1;
      #1; en_par = 1'b0;
      @(posedge clk); #2;
      check("R9", "glitch ignored", q, model);
    end

    // Clear between edges with load still requested.
    @(negedge clk);
    load_n = 1'b0; din = 12'h5A5; en_par = 1'b1; en_trk = 1'b1;
    #1; clr_n = 1'b0; #1;
    check("R1", "async clear mid-cycle", q, '0);
    check("R1", "tc cleared", TW'(tc), '0);
    @(posedge clk); #2;
    check("R8", "clear over load at edge", q, '0);
    @(negedge clk);
    clr_n = 1'b1;
    model = '0;
    cycle(1'b0, 1'b0, 1'b1, 12'hFFE);
    cycle(1'b1, 1'b1, 1'b1, '0);
    cycle(1'b1, 1'b1, 1'b1, '0);

    // Random patterns, with load weighted low.
    for (int r = 0; r < 3000; r++) begin
      logic [3:0] pick;
      pick = 4'($urandom);
      cycle(pick != 4'd0, ($urandom % 4) != 0, ($urandom % 4) != 0,
            ($urandom % 3 == 0) ? (ALL_ONES - TW'($urandom % 3)) : TW'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule